// File: doc/BRIEF.md
# Programmable Clock Divider with Load Request and Lock Flag

This block divides a reference clock by a programmable ratio and controls it through one 32-bit control word on a plain write/readback bus. Software writes a ratio into a shadow field. The running output period changes only when a write also sets the load-request bit. The block then drops its lock flag, restarts its period counter at the new ratio, and raises the flag again once one full period of the new ratio has run. A ratio of zero behaves exactly like a ratio of one.

The control word also holds an output enable, a reset for the divider domain, and a gate bit for the buffered reference. The divided output is a registered level that runs in the reference clock domain. Two build parameters pick the variant. One moves the lock flag to a lower bit position. The other makes every load request clear the enable, so the output stays gated while the ratio settles and software turns it back on after it sees lock.

Top module: `clkdiv_lock_top`

## Requirements
- R1: After the system reset, the readback word is all zeros. Readback shows enable at bit 0, divider reset at bit 1, the shadow ratio in bits 4 and up (DIV_W bits wide), the reference gate at bit 28, and the lock flag. Bit 2 and every other bit read as 0.
- R2: A write with bit 2 set copies the ratio field of that same write into the active ratio. At that clock edge the period counter restarts at phase 0, and the output goes high on the next cycle if enabled.
- R3: A write with bit 2 clear updates only the shadow field. The output period keeps the active ratio.
- R4: The effective ratio N is max(ratio, 1). While the counter runs, the output repeats every N reference cycles.
- R5: Each period starts with floor(N/2) high cycles followed by low cycles. When N is 1 the output stays high.
- R6: While enable (bit 0) is 0, the output is low. The counter keeps running, so its phase is kept.
- R7: The lock flag is low in the cycle after an accepted load request. It rises exactly N cycles after the load edge, which is always within 4·N cycles.
- R8: While the divider reset bit (bit 1) is 1, the counter is held at phase 0, the output is low and lock is low. After release, lock rises N cycles later.
- R9: The reference buffer enable output is the inverse of bit 28: writing 1 stops the buffered reference and writing 0 lets it pass.
- R10: With GATE_ON_LOAD=1, a write that sets bit 2 leaves enable at 0, whatever bit 0 of that write holds.
- R11: The lock flag reads at bit 31, or at bit 27 when LOCK_SHIFT=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high system reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback, including lock |
| div_clk_o | output | 1 | Divided output level (registered) |
| lock_o | output | 1 | Lock flag |
| ref_buf_en_o | output | 1 | Reference buffer pass enable |

## Verification
The hardest situation to reach is a load request that arrives while the counter is mid-period, or while the divider reset is held. In either case, the restart point and the lock timing depend on which condition wins at that edge. The stimulus fires loads at odd phases of long and short ratios, writes shadow-only ratios between them, and asserts a load while the divider reset is set. It also runs the largest ratio, so that the lock latency reaches its longest value. A behavioural model in the bench follows every cycle of the output, the lock flag and the readback for both build variants.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int EN_POS        = 0;
  localparam int DRST_POS      = 1;
  localparam int LOAD_POS      = 2;
  localparam int RATIO_LSB     = 4;
  localparam int GATE_POS      = 28;
  localparam int LOCK_POS_STD  = 31;
  localparam int LOCK_POS_ALT  = 27;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int LOCK_SHIFT   = 0,
  parameter int GATE_ON_LOAD = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  input  logic             lock_i,
  output logic [31:0]      rdata_o,
  output logic             en_o,
  output logic             drst_o,
  output logic             gate_o,
  output logic             load_o,
  output logic [DIV_W-1:0] load_ratio_o
);
  localparam int LOCK_POS = (LOCK_SHIFT != 0) ? LOCK_POS_ALT : LOCK_POS_STD;

  logic             en_q, drst_q, gate_q;
  logic [DIV_W-1:0] shadow_q;
  logic             en_wr;

  assign load_o       = wr_i & wdata_i[LOAD_POS];
  assign load_ratio_o = wdata_i[RATIO_LSB +: DIV_W];

  generate
    if (GATE_ON_LOAD != 0) begin : g_gated
      assign en_wr = wdata_i[EN_POS] & ~wdata_i[LOAD_POS];
    end else begin : g_free
      assign en_wr = wdata_i[EN_POS];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      drst_q   <= 1'b0;
      gate_q   <= 1'b0;
      shadow_q <= '0;
    end else if (wr_i) begin
      en_q     <= en_wr;
      drst_q   <= wdata_i[DRST_POS];
      gate_q   <= wdata_i[GATE_POS];
      shadow_q <= wdata_i[RATIO_LSB +: DIV_W];
    end
  end

  always_comb begin
    rdata_o                      = '0;
    rdata_o[EN_POS]              = en_q;
    rdata_o[DRST_POS]            = drst_q;
    rdata_o[RATIO_LSB +: DIV_W]  = shadow_q;
    rdata_o[GATE_POS]            = gate_q;
    rdata_o[LOCK_POS]            = lock_i;
  end

  assign en_o   = en_q;
  assign drst_o = drst_q;
  assign gate_o = gate_q;

  generate
    if (GATE_ON_LOAD != 0) begin : g_chk_gated
      // R10: a load request leaves the enable cleared
      p_load_gates_r10: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !en_o);
    end
  endgenerate
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             drst_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_ratio_i,
  output logic [DIV_W-1:0] ratio_eff_o,
  output logic             div_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] act_q, cnt_q;
  logic [DIV_W-1:0] act_nxt, cnt_nxt, n_cur, n_nxt;
  logic             hi_nxt;

  always_comb begin
    n_cur   = (act_q == '0) ? ONE : act_q;
    act_nxt = act_q;
    if (load_i) begin
      act_nxt = load_ratio_i;
      cnt_nxt = '0;
    end else if (drst_i) begin
      cnt_nxt = '0;
    end else begin
      cnt_nxt = (cnt_q >= n_cur - ONE) ? '0 : cnt_q + ONE;
    end
    n_nxt  = (act_nxt == '0) ? ONE : act_nxt;
    hi_nxt = (n_nxt == ONE) || (cnt_nxt < (n_nxt >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
      div_o <= 1'b0;
    end else begin
      act_q <= act_nxt;
      cnt_q <= cnt_nxt;
      div_o <= en_i & ~drst_i & hi_nxt;
    end
  end

  assign ratio_eff_o = n_cur;

  // R3: the active ratio moves only on a load request
  p_ratio_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(act_q));
  // R4: the phase counter stays inside the effective period
  p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < n_cur);
  // R6: output low after a cycle with enable cleared
  p_hold_low_r6: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !div_o);
  // R8: divider reset parks the counter at phase 0
  p_park_phase_r8: assert property (@(posedge clk) disable iff (rst)
    drst_i |=> (cnt_q == '0) && !div_o);
endmodule

// File: rtl/clkdiv_lock.sv
module clkdiv_lock #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drst_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] ratio_eff_i,
  output logic             lock_o
);
  logic [DIV_W-1:0] settle_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_o   <= 1'b0;
      busy_q   <= 1'b1;
      settle_q <= '0;
    end else if (drst_i || load_i) begin
      lock_o   <= 1'b0;
      busy_q   <= 1'b1;
      settle_q <= '0;
    end else if (busy_q) begin
      if (settle_q == ratio_eff_i - DIV_W'(1)) begin
        lock_o <= 1'b1;
        busy_q <= 1'b0;
      end else begin
        settle_q <= settle_q + DIV_W'(1);
      end
    end
  end

  // R7: an accepted load request drops lock
  p_lock_drop_r7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !lock_o);
  // R7: settling never runs past one new period, well inside the 4N bound
  p_lock_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (settle_q < ratio_eff_i));
  // R8: divider reset keeps lock low
  p_lock_rst_r8: assert property (@(posedge clk) disable iff (rst)
    drst_i |=> !lock_o);
endmodule

// File: rtl/clkdiv_lock_top.sv
module clkdiv_lock_top #(
  parameter int DIV_W        = 8,
  parameter int LOCK_SHIFT   = 0,
  parameter int GATE_ON_LOAD = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        div_clk_o,
  output logic        lock_o,
  output logic        ref_buf_en_o
);
  logic             en, drst, gate, load;
  logic [DIV_W-1:0] load_ratio, ratio_eff;

  clkdiv_regs #(
    .DIV_W(DIV_W), .LOCK_SHIFT(LOCK_SHIFT), .GATE_ON_LOAD(GATE_ON_LOAD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .wdata_i(reg_wdata),
    .lock_i(lock_o), .rdata_o(reg_rdata), .en_o(en), .drst_o(drst),
    .gate_o(gate), .load_o(load), .load_ratio_o(load_ratio)
  );

  clkdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en), .drst_i(drst), .load_i(load),
    .load_ratio_i(load_ratio), .ratio_eff_o(ratio_eff), .div_o(div_clk_o)
  );

  clkdiv_lock #(.DIV_W(DIV_W)) u_lock (
    .clk(clk), .rst(rst), .drst_i(drst), .load_i(load),
    .ratio_eff_i(ratio_eff), .lock_o(lock_o)
  );

  assign ref_buf_en_o = ~gate;
endmodule

// File: tb/tb_clkdiv_lock_top.sv
module clkdiv_ref_model #(
  parameter int GATED = 0,
  parameter int LPOS  = 31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wd,
  output logic [31:0] rd_e,
  output logic        div_e,
  output logic        lock_e,
  output logic        buf_e
);
  int en, drs, shd, gb, act, cnt, lk, busy, st;
  initial begin
    en = 0; drs = 0; shd = 0; gb = 0; act = 0; cnt = 0; lk = 0; busy = 1; st = 0;
    rd_e = '0; div_e = 0; lock_e = 0; buf_e = 1;
  end
  always @(posedge clk) begin
    int n, nact, ncnt, nn, ld, fld;
    if (rst) begin
      en = 0; drs = 0; shd = 0; gb = 0; act = 0; cnt = 0; lk = 0; busy = 1; st = 0;
      div_e = 0;
    end else begin
      ld  = (wr && wd[2]) ? 1 : 0;
      fld = int'(wd[11:4]);
      n   = (act == 0) ? 1 : act;
      nact = act;
      if (ld) begin nact = fld; ncnt = 0; end
      else if (drs) ncnt = 0;
      else ncnt = (cnt + 1) % n;
      nn = (nact == 0) ? 1 : nact;
      div_e = en && !drs && (nn == 1 || ncnt < nn / 2);
      if (drs || ld) begin lk = 0; busy = 1; st = 0; end
      else if (busy) begin
        if (st == n - 1) begin lk = 1; busy = 0; end
        else st = st + 1;
      end
      act = nact; cnt = ncnt;
      if (wr) begin
        en  = (wd[0] && !(GATED != 0 && wd[2])) ? 1 : 0;
        drs = wd[1] ? 1 : 0;
        shd = fld;
        gb  = wd[28] ? 1 : 0;
      end
    end
    rd_e = '0;
    rd_e[0] = en[0]; rd_e[1] = drs[0]; rd_e[11:4] = shd[7:0];
    rd_e[28] = gb[0]; rd_e[LPOS] = lk[0];
    lock_e = lk[0];
    buf_e = !gb[0];
  end
endmodule

module tb_clkdiv_lock_top;
  logic clk = 0;
  logic rst = 1;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd0, rd1, e_rd0, e_rd1;
  logic dv0, dv1, lk0, lk1, bf0, bf1, e_dv0, e_dv1, e_lk0, e_lk1, e_bf0, e_bf1;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic cmp_on = 0;

  always #5 clk = ~clk;

  clkdiv_lock_top dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd0), .div_clk_o(dv0), .lock_o(lk0), .ref_buf_en_o(bf0));
  clkdiv_lock_top #(.LOCK_SHIFT(1), .GATE_ON_LOAD(1)) dut_g (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd1), .div_clk_o(dv1), .lock_o(lk1), .ref_buf_en_o(bf1));

  clkdiv_ref_model #(.GATED(0), .LPOS(31)) m0 (
    .clk(clk), .rst(rst), .wr(reg_wr), .wd(reg_wdata),
    .rd_e(e_rd0), .div_e(e_dv0), .lock_e(e_lk0), .buf_e(e_bf0));
  clkdiv_ref_model #(.GATED(1), .LPOS(27)) m1 (
    .clk(clk), .rst(rst), .wr(reg_wr), .wd(reg_wdata),
    .rd_e(e_rd1), .div_e(e_dv1), .lock_e(e_lk1), .buf_e(e_bf1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word(input int en, input int drs, input int ld,
                                       input int ratio, input int gb);
    logic [31:0] w;
    w = '0;
    w[0] = en[0]; w[1] = drs[0]; w[2] = ld[0]; w[11:4] = ratio[7:0]; w[28] = gb[0];
    return w;
  endfunction

  task automatic wr_reg(input logic [31:0] v);
    reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // R7: count cycles from the load edge until lock is seen
  task automatic load_and_time(input int en, input int ratio);
    int t, n;
    n = (ratio == 0) ? 1 : ratio;
    wr_reg(word(en, 0, 1, ratio, 0));
    check("R7 lock low after load", {31'd0, lk0}, 32'd0);
    t = 0;
    while (!lk0 && t < 5 * n) begin @(negedge clk); t++; end
    check("R7 lock latency", t, n);
    check("R7 lock within 4N", (t <= 4 * n) ? 1 : 0, 1);
  endtask

  // R5: count high samples over two periods
  task automatic duty(input int n);
    int h;
    h = 0;
    for (int i = 0; i < 2 * n; i++) begin @(negedge clk); h += dv0 ? 1 : 0; end
    check("R5 high count over two periods", h, (n == 1) ? 2 : 2 * (n / 2));
  endtask

  always @(posedge clk) begin
    #3;
    if (cmp_on) begin
      check("R2 R3 R4 R5 R6 div out", {31'd0, dv0}, {31'd0, e_dv0});
      check("R10 div out gated", {31'd0, dv1}, {31'd0, e_dv1});
      check("R7 R8 lock", {31'd0, lk0}, {31'd0, e_lk0});
      check("R11 lock shifted build", {31'd0, lk1}, {31'd0, e_lk1});
      check("R9 ref buffer", {30'd0, bf1, bf0}, {30'd0, e_bf1, e_bf0});
      check("R1 readback", rd0, e_rd0);
      check("R11 R10 readback gated", rd1, e_rd1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 reset readback", rd0, 32'd0);
    check("R1 reset lock", {31'd0, lk0}, 32'd0);
    rst = 0;
    cmp_on = 1;
    idle(4);
    load_and_time(1, 4);
    duty(4);
    // R3: shadow-only write keeps period 4
    wr_reg(word(1, 0, 0, 7, 0));
    check("R3 shadow readback", {24'd0, rd0[11:4]}, 32'd7);
    duty(4);
    idle(1);
    load_and_time(1, 7);
    duty(7);
    idle(2);
    load_and_time(1, 0);
    idle(3);
    check("R4 ratio zero holds high", {31'd0, dv0}, 32'd1);
    load_and_time(1, 1);
    duty(1);
    load_and_time(1, 2);
    duty(2);
    load_and_time(1, 3);
    duty(3);
    check("R10 gated build enable cleared", {31'd0, rd1[0]}, 32'd0);
    check("R11 lock at bit 27", {31'd0, rd1[27]}, {31'd0, lk1});
    idle(1);
    // R2: load mid-period
    wr_reg(word(1, 0, 0, 5, 0));
    wr_reg(word(1, 0, 1, 6, 0));
    idle(9);
    // R6: enable off keeps output low
    wr_reg(word(0, 0, 0, 6, 0));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R6 output low while disabled", {31'd0, dv0}, 32'd0);
    end
    wr_reg(word(1, 0, 0, 6, 0));
    idle(5);
    // R8: divider reset, then load while in reset, then release
    wr_reg(word(1, 1, 0, 6, 0));
    idle(3);
    check("R8 lock low in divider reset", {31'd0, lk0}, 32'd0);
    check("R8 output low in divider reset", {31'd0, dv0}, 32'd0);
    wr_reg(word(1, 1, 1, 5, 0));
    idle(3);
    wr_reg(word(1, 0, 0, 5, 0));
    idle(12);
    // R9: reference gate
    wr_reg(word(1, 0, 0, 5, 1));
    check("R9 gate stops buffer", {31'd0, bf0}, 32'd0);
    wr_reg(word(1, 0, 0, 5, 0));
    check("R9 gate clear passes buffer", {31'd0, bf0}, 32'd1);
    load_and_time(1, 255);
    duty(255);
    wr_reg(word(1, 0, 1, 3, 0));
    idle(20);
    cmp_on = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule